// File: doc/BRIEF.md
# UART Register and Interrupt Block

This block is the register face of a simple UART on a word-wide memory-mapped port. A receiver outside it hands over bytes one at a time on a push strobe. They are held in a receive queue until software reads the data register. A write to the data register puts its low byte on a transmit strobe for one cycle. The serial shifter, the baud generator, DMA and line-error handling are outside the block. The divisor, low-power, control and DMA-control registers are plain storage.

The block keeps flag, line-control, level-select, interrupt-mask, raw-status, masked-status, clear and receive-status registers. It also has an eight-byte read-only identification window. One level-sensitive interrupt line is raised whenever an enabled raw status bit is set.

Each cycle carries at most one bus access. The effects of that access are applied first, and a receive push in the same cycle is applied after them. Read data is combinational from the state before the clock edge. A data read removes its byte at that edge.

Top module: `sio_regfile`

## Requirements
- R1: After reset the flags word (index 6) reads 0x90, control (index 12) reads 0x300 and level select (index 13) reads 0x12. Every other register reads 0 and `irq` is low.
- R2: The storage registers are low-power (index 8), integer divisor (9), fractional divisor (10), line control (11), control (12), level select (13), mask (14) and DMA control (18). Each reads back the full 32-bit word last written. Writes to the flags word (6) change nothing.
- R3: Bytes leave the receive queue in arrival order. The queue holds 16 bytes when line-control bit 4 is 1 and 1 byte when it is 0. A push into a full queue is dropped and sets bit 3 of receive status (index 1). Any write to index 1 clears it.
- R4: Flag bit 4 is set exactly when the queue is empty. Flag bit 6 is set by a push when line-control bit 4 is 0 or the count reaches 16. It is cleared by any data read. Bit 7 always reads 1.
- R5: Raw bit 4 (receive) is set by a push that leaves the count at or above the trigger level. It is cleared by a data read that leaves the count at trigger minus 1. The trigger level is 1 after reset and after any write to index 11 or 13. A data read from an empty queue returns 0.
- R6: A write to the data register (index 0) sets raw bit 5 (transmit). In the next cycle `tx_valid` is high for one cycle with `tx_byte` equal to bits 7:0 of the written word.
- R7: Index 15 reads raw status and index 16 reads raw AND mask. `irq` is high exactly when that AND is nonzero. Writing index 17 clears the raw bits written as 1.
- R8: A line-control write that changes bit 4 empties the receive queue. A line-control write that keeps bit 4 leaves the contents untouched.
- R9: Byte offsets 0xFE0 to 0xFFC read the bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in increasing address order. Unmapped indices and offsets with nonzero bits 1:0 read 0, and writes to them do nothing.
- R10: When a push coincides with a bus access, the access acts first. A data read pops before the push is counted, and a clear of raw bit 4 is overridden by a push that sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_push | input | 1 | A received byte is offered |
| rx_byte | input | 8 | The received byte |
| tx_valid | output | 1 | One-cycle strobe of a transmitted byte |
| tx_byte | output | 8 | The transmitted byte |
| irq | output | 1 | Interrupt request, level |

## Verification
A bad queue count shows up at the ports in several ways. The full or empty flag disagrees with the number of bytes pushed, bytes come back out of order or as zeros, and a drop is flagged too early or not at all. Each of these is visible at the first flag or data read after the fault. A wrong raw-status update shows on `irq` in the very next cycle when the bit is unmasked. The same fault shows on index 15 at any later read. The bench keeps its own model of the queue and status words and compares `irq` and the transmit strobe on every cycle. It compares `bus_rdata` on every read, so a divergence is reported in the cycle it becomes observable.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int WIDX_W = ADDR_W - 2;

  typedef logic [WIDX_W-1:0] widx_t;
  typedef logic [WORD_W-1:0] word_t;

  // word indices (byte offset / 4)
  localparam widx_t IX_DATA  = 10'd0;
  localparam widx_t IX_RXST  = 10'd1;
  localparam widx_t IX_FLAG  = 10'd6;
  localparam widx_t IX_LPWR  = 10'd8;
  localparam widx_t IX_DIVI  = 10'd9;
  localparam widx_t IX_DIVF  = 10'd10;
  localparam widx_t IX_LINE  = 10'd11;
  localparam widx_t IX_CTRL  = 10'd12;
  localparam widx_t IX_LVL   = 10'd13;
  localparam widx_t IX_MASK  = 10'd14;
  localparam widx_t IX_RAW   = 10'd15;
  localparam widx_t IX_MSTAT = 10'd16;
  localparam widx_t IX_CLR   = 10'd17;
  localparam widx_t IX_DMA   = 10'd18;
  localparam widx_t IX_ID_LO = 10'h3F8;

  // bit positions
  localparam int FEN_BIT   = 4;
  localparam int RXI_BIT   = 4;
  localparam int TXI_BIT   = 5;
  localparam int RXE_FLAG  = 4;
  localparam int RXF_FLAG  = 6;
  localparam int TXE_FLAG  = 7;
  localparam int OVR_BIT   = 3;

  localparam word_t CTRL_RST = 32'h0000_0300;
  localparam word_t LVL_RST  = 32'h0000_0012;

  // identification window contents
  function automatic logic [7:0] id_byte(input logic [2:0] sel);
    case (sel)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  // compose the flags word from its live bits
  function automatic word_t flag_word(input logic full, input logic empty);
    word_t w;
    w = '0;
    w[TXE_FLAG] = 1'b1;
    w[RXF_FLAG] = full;
    w[RXE_FLAG] = empty;
    return w;
  endfunction

  // place the two raw event bits into a status word
  function automatic word_t raw_word(input logic [1:0] ev);
    word_t w;
    w = '0;
    w[RXI_BIT] = ev[0];
    w[TXI_BIT] = ev[1];
    return w;
  endfunction
endpackage

// File: rtl/sio_rx_queue.sv
module sio_rx_queue #(
  parameter int DEPTH = 16,
  parameter int BYTE_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              pop,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, wr_eff;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign head   = mem[rd_ptr];
  assign wr_eff = flush ? '0 : wr_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_eff] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= push ? ptr_inc('0) : '0;
      count  <= push ? CNT_W'(1) : '0;
    end else begin
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R3: storage never holds more than its depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: an accepted push is never made into a full store
  p_push_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (count < CNT_W'(DEPTH)));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_we,
  input  word_t      mask_wdata,
  input  logic       clr_we,
  input  logic [1:0] clr_bits,   // {tx, rx}
  input  logic       rx_clr,
  input  logic       rx_set,
  input  logic       tx_set,
  output logic [1:0] raw_q,      // {tx, rx}
  output word_t      mask_q,
  output logic       irq
);
  logic [1:0] after_bus;

  always_comb begin
    after_bus = raw_q;
    if (clr_we) after_bus = after_bus & ~clr_bits;
    if (rx_clr) after_bus[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= after_bus | {tx_set, rx_set};
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign irq = |(raw_word(raw_q) & mask_q);

  // R7: a clear of the transmit bit with no new transmit leaves it low
  p_clear_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[1] && !tx_set) |=> !raw_q[1]);

  // R10: a receive set wins over any clear in the same cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> raw_q[0]);

  // R6: a transmit event is always recorded
  p_tx_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> raw_q[1]);
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_pkg::*;
(
  input  widx_t       widx,
  input  logic        aligned,
  input  logic        head_vld,
  input  logic [7:0]  head_byte,
  input  logic        ovr_err,
  input  logic        rx_full,
  input  logic        rx_empty,
  input  word_t       lpwr,
  input  word_t       divi,
  input  word_t       divf,
  input  word_t       line,
  input  word_t       ctrl,
  input  word_t       lvl,
  input  word_t       mask,
  input  logic [1:0]  raw,
  input  word_t       dma,
  output word_t       rdata
);
  word_t raw_w;
  assign raw_w = raw_word(raw);

  always_comb begin
    rdata = '0;
    if (!aligned) begin
      rdata = '0;
    end else if (widx >= IX_ID_LO) begin
      rdata = {24'd0, id_byte(widx[2:0])};
    end else begin
      case (widx)
        IX_DATA:  rdata = head_vld ? {24'd0, head_byte} : '0;
        IX_RXST:  rdata = {28'd0, ovr_err, 3'd0};
        IX_FLAG:  rdata = flag_word(rx_full, rx_empty);
        IX_LPWR:  rdata = lpwr;
        IX_DIVI:  rdata = divi;
        IX_DIVF:  rdata = divf;
        IX_LINE:  rdata = line;
        IX_CTRL:  rdata = ctrl;
        IX_LVL:   rdata = lvl;
        IX_MASK:  rdata = mask;
        IX_RAW:   rdata = raw_w;
        IX_MSTAT: rdata = raw_w & mask;
        IX_DMA:   rdata = dma;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int RXQ_DEPTH    = 16,
  parameter int RX_TRIG_INIT = 1,
  localparam int CNT_W = $clog2(RXQ_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  // queue capacity for the current mode
  function automatic logic [CNT_W-1:0] cap_of(input logic fen);
    return fen ? CNT_W'(RXQ_DEPTH) : CNT_W'(1);
  endfunction

  // decode
  widx_t widx;
  logic  aligned, wr, rd;
  logic  data_wr, data_rd, line_wr, lvl_wr, rxst_wr;
  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_sel && bus_we && aligned;
  assign rd      = bus_sel && !bus_we && aligned;
  assign data_wr = wr && (widx == IX_DATA);
  assign data_rd = rd && (widx == IX_DATA);
  assign line_wr = wr && (widx == IX_LINE);
  assign lvl_wr  = wr && (widx == IX_LVL);
  assign rxst_wr = wr && (widx == IX_RXST);

  // storage registers
  word_t lpwr_q, divi_q, divf_q, line_q, ctrl_q, lvl_q, dma_q;
  logic  ovr_q, rx_empty_q, rx_full_q;
  logic [CNT_W-1:0] trig_q;
  logic [CNT_W-1:0] rxq_cnt;
  logic [7:0]       rxq_head;

  // internal events, named for the checks
  logic             fen_toggle, fen_after;
  logic             pop_ok, push_ok, push_drop;
  logic [CNT_W-1:0] cnt_after_bus, cnt_final, trig_after;
  logic             rx_clr_evt, rx_set_evt;
  logic             empty_nx, full_nx;

  assign fen_toggle = line_wr && (bus_wdata[FEN_BIT] != line_q[FEN_BIT]);
  assign fen_after  = line_wr ? bus_wdata[FEN_BIT] : line_q[FEN_BIT];
  assign pop_ok     = data_rd && (rxq_cnt != '0);

  always_comb begin
    if (fen_toggle)  cnt_after_bus = '0;
    else if (pop_ok) cnt_after_bus = rxq_cnt - CNT_W'(1);
    else             cnt_after_bus = rxq_cnt;
  end

  assign push_ok    = rx_push && (cnt_after_bus < cap_of(fen_after));
  assign push_drop  = rx_push && !push_ok;
  assign cnt_final  = cnt_after_bus + CNT_W'(push_ok);
  assign trig_after = (line_wr || lvl_wr) ? CNT_W'(RX_TRIG_INIT) : trig_q;
  assign rx_clr_evt = data_rd && (cnt_after_bus == trig_q - CNT_W'(1));
  assign rx_set_evt = rx_push && (cnt_final >= trig_after);

  // flag rules, bus access first then push
  always_comb begin
    empty_nx = rx_empty_q;
    full_nx  = rx_full_q;
    if (fen_toggle) begin
      empty_nx = 1'b1;
      full_nx  = 1'b0;
    end
    if (data_rd) begin
      full_nx = 1'b0;
      if (cnt_after_bus == '0) empty_nx = 1'b1;
    end
    if (rx_push) begin
      empty_nx = 1'b0;
      if (!fen_after || cnt_final == CNT_W'(RXQ_DEPTH)) full_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpwr_q     <= '0;
      divi_q     <= '0;
      divf_q     <= '0;
      line_q     <= '0;
      ctrl_q     <= CTRL_RST;
      lvl_q      <= LVL_RST;
      dma_q      <= '0;
      ovr_q      <= 1'b0;
      rx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      trig_q     <= CNT_W'(RX_TRIG_INIT);
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
    end else begin
      if (wr) begin
        case (widx)
          IX_LPWR: lpwr_q <= bus_wdata;
          IX_DIVI: divi_q <= bus_wdata;
          IX_DIVF: divf_q <= bus_wdata;
          IX_LINE: line_q <= bus_wdata;
          IX_CTRL: ctrl_q <= bus_wdata;
          IX_LVL:  lvl_q  <= bus_wdata;
          IX_DMA:  dma_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (push_drop)    ovr_q <= 1'b1;
      else if (rxst_wr) ovr_q <= 1'b0;
      rx_empty_q <= empty_nx;
      rx_full_q  <= full_nx;
      trig_q     <= trig_after;
      tx_valid   <= data_wr;
      if (data_wr) tx_byte <= bus_wdata[7:0];
    end
  end

  sio_rx_queue #(.DEPTH(RXQ_DEPTH), .BYTE_W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (fen_toggle),
    .pop   (pop_ok),
    .push  (push_ok),
    .din   (rx_byte),
    .head  (rxq_head),
    .count (rxq_cnt)
  );

  logic [1:0] raw_q;
  word_t      mask_q;

  sio_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (wr && (widx == IX_MASK)),
    .mask_wdata (bus_wdata),
    .clr_we     (wr && (widx == IX_CLR)),
    .clr_bits   ({bus_wdata[TXI_BIT], bus_wdata[RXI_BIT]}),
    .rx_clr     (rx_clr_evt),
    .rx_set     (rx_set_evt),
    .tx_set     (data_wr),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .irq        (irq)
  );

  sio_rd_mux u_rdmux (
    .widx      (widx),
    .aligned   (aligned),
    .head_vld  (rxq_cnt != '0),
    .head_byte (rxq_head),
    .ovr_err   (ovr_q),
    .rx_full   (rx_full_q),
    .rx_empty  (rx_empty_q),
    .lpwr      (lpwr_q),
    .divi      (divi_q),
    .divf      (divf_q),
    .line      (line_q),
    .ctrl      (ctrl_q),
    .lvl       (lvl_q),
    .mask      (mask_q),
    .raw       (raw_q),
    .dma       (dma_q),
    .rdata     (bus_rdata)
  );

  // R4: the empty flag agrees with the queue count
  p_empty_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty_q == (rxq_cnt == '0));

  // R4: the full flag agrees with the count and the current mode
  p_full_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_q == (rxq_cnt == cap_of(line_q[FEN_BIT])));

  // R3: a dropped push raises the overrun bit
  p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovr_q);

  // R6: a data write produces one transmit strobe
  p_tx_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));

  // R8: a mode change with no push leaves the queue empty
  p_toggle_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fen_toggle && !rx_push) |=> (rxq_cnt == '0));

  // R5: the trigger level only ever holds its initial value
  p_trig_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q == CNT_W'(RX_TRIG_INIT));
endmodule

// File: tb/sio_regfile_tb_top.sv
module sio_regfile_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid, irq;
  logic [7:0]  tx_byte;

  always #(CLK_NS/2) clk = ~clk;

  sio_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned q[$];
  int unsigned m_lpwr, m_divi, m_divf, m_line, m_ctrl, m_lvl, m_mask, m_raw, m_dma, m_rxst;
  bit m_full, m_empty, m_txv;
  byte unsigned m_txb;
  int m_trig;
  byte unsigned id_tab[8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic model_reset();
    q.delete();
    m_lpwr = 0; m_divi = 0; m_divf = 0; m_line = 0; m_ctrl = 32'h300; m_lvl = 32'h12;
    m_mask = 0; m_raw = 0; m_dma = 0; m_rxst = 0;
    m_full = 0; m_empty = 1; m_txv = 0; m_txb = 0; m_trig = 1;
  endtask

  function automatic int unsigned model_read(input int unsigned addr);
    int unsigned ix;
    if (addr % 4 != 0) return 0;
    ix = addr / 4;
    if (addr >= 12'hFE0) return id_tab[(addr - 12'hFE0) / 4];
    case (ix)
      0:  return (q.size() > 0) ? q[0] : 0;
      1:  return m_rxst;
      6:  return 32'h80 | (m_full ? 32'h40 : 0) | (m_empty ? 32'h10 : 0);
      8:  return m_lpwr;
      9:  return m_divi;
      10: return m_divf;
      11: return m_line;
      12: return m_ctrl;
      13: return m_lvl;
      14: return m_mask;
      15: return m_raw;
      16: return m_raw & m_mask;
      18: return m_dma;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge(input bit sel, input bit we, input int unsigned addr,
                            input int unsigned wd, input bit push, input byte unsigned b);
    int cap;
    bit ok;
    ok = sel && (addr % 4 == 0) && (addr < 12'hFE0);
    m_txv = 0;
    if (ok && we) begin
      case (addr / 4)
        0:  begin m_raw |= 32'h20; m_txv = 1; m_txb = wd[7:0]; end
        1:  m_rxst = 0;
        8:  m_lpwr = wd;
        9:  m_divi = wd;
        10: m_divf = wd;
        11: begin
              if (((m_line ^ wd) & 32'h10) != 0) begin q.delete(); m_empty = 1; m_full = 0; end
              m_line = wd; m_trig = 1;
            end
        12: m_ctrl = wd;
        13: begin m_lvl = wd; m_trig = 1; end
        14: m_mask = wd;
        17: m_raw &= ~wd;
        18: m_dma = wd;
        default: ;
      endcase
    end else if (ok && !we && addr == 0) begin
      m_full = 0;
      if (q.size() > 0) void'(q.pop_front());
      if (q.size() == 0) m_empty = 1;
      if (q.size() == m_trig - 1) m_raw &= ~32'h10;
    end
    if (push) begin
      cap = m_line[4] ? 16 : 1;
      if (q.size() < cap) q.push_back(b);
      else m_rxst |= 32'h8;
      m_empty = 0;
      if (!m_line[4] || q.size() == 16) m_full = 1;
      if (q.size() >= m_trig) m_raw |= 32'h10;
    end
    m_raw &= 32'h30;
  endtask

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one cycle: compare per-cycle outputs, drive, compare read data, clock, advance model
  task automatic step(input bit sel, input bit we, input int unsigned addr, input int unsigned wd,
                      input bit push, input byte unsigned b, input string tag);
    @(negedge clk);
    chk({tag, " irq"}, irq, ((m_raw & m_mask) != 0) ? 1 : 0);
    chk({tag, " tx_valid"}, tx_valid, m_txv);
    if (m_txv) chk({tag, " tx_byte"}, tx_byte, m_txb);
    bus_sel = sel; bus_we = we; bus_addr = addr[11:0]; bus_wdata = wd;
    rx_push = push; rx_byte = b;
    #1;
    if (sel && !we) chk({tag, " rdata"}, bus_rdata, model_read(addr));
    @(posedge clk);
    model_edge(sel, we, addr, wd, push, b);
  endtask

  task automatic rd(input int unsigned a, input string t);                step(1, 0, a, 0, 0, 0, t); endtask
  task automatic wr(input int unsigned a, input int unsigned d, input string t); step(1, 1, a, d, 0, 0, t); endtask
  task automatic psh(input byte unsigned b, input string t);             step(0, 0, 0, 0, 1, b, t); endtask
  task automatic idle(input string t);                                    step(0, 0, 0, 0, 0, 0, t); endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values, every mapped index
    chk("R1 irq at reset", irq, 0);
    for (int i = 0; i < 19; i++) rd(i * 4, "R1");

    // R2: storage read-back and ignored flag writes
    wr(32, 32'hA5A5_0001, "R2"); wr(36, 32'h0000_0027, "R2"); wr(40, 32'h0000_0011, "R2");
    wr(48, 32'h0000_0B01, "R2"); wr(72, 32'h0000_0003, "R2"); wr(52, 32'hDEAD_BEEF, "R2");
    for (int i = 8; i < 19; i++) rd(i * 4, "R2");
    wr(24, 32'hFFFF_FFFF, "R2 flag write"); rd(24, "R2 flag unchanged");

    // R3/R4: single-entry mode, drop and error clear
    psh(8'h41, "R4 push"); rd(24, "R4 full single");
    psh(8'h42, "R3 drop"); rd(4, "R3 overrun set");
    rd(0, "R3 first byte"); rd(24, "R4 empty after read");
    rd(0, "R5 empty read zero");
    wr(4, 0, "R3 clear"); rd(4, "R3 overrun cleared");

    // R8: enable queue mode (flush), fill to the limit
    wr(44, 32'h10, "R8 enable");
    for (int i = 0; i < 16; i++) psh(byte'(8'h60 + i), "R3 fill");
    rd(24, "R4 full at 16");
    psh(8'hEE, "R3 drop 17th"); rd(4, "R3 overrun deep");
    for (int i = 0; i < 16; i++) rd(0, "R3 order");
    rd(24, "R4 empty after drain");
    wr(4, 0, "R3 clear again");

    // R5/R7: receive interrupt through the mask
    wr(56, 32'h10, "R7 mask rx");
    psh(8'h31, "R5 set"); idle("R5 irq high"); rd(60, "R5 raw"); rd(64, "R7 masked");
    psh(8'h32, "R5 second"); rd(0, "R5 read keeps"); rd(60, "R5 still set");
    rd(0, "R5 read clears"); rd(60, "R5 cleared");

    // R6/R7: transmit strobe and clear
    wr(0, 32'h0000_01A5, "R6 tx"); idle("R6 strobe"); rd(60, "R6 raw tx");
    wr(56, 32'h30, "R7 mask both"); idle("R7 irq tx");
    wr(68, 32'h20, "R7 clear tx"); rd(64, "R7 masked after clear");
    wr(0, 32'h3C, "R6 tx again"); wr(0, 32'h3D, "R6 back to back"); idle("R6 tail");

    // R10: clear and push together, read and push together
    step(1, 1, 68, 32'h30, 1, 8'h77, "R10 clear vs set"); rd(60, "R10 set wins");
    psh(8'h78, "R10 fill");
    step(1, 0, 0, 0, 1, 8'h79, "R10 read with push");
    rd(0, "R10 order a"); rd(0, "R10 order b"); rd(0, "R10 empty");

    // R8: same-mode write keeps data, mode change empties
    psh(8'h90, "R8 push"); psh(8'h91, "R8 push");
    wr(44, 32'h70, "R8 same mode"); rd(0, "R8 kept");
    wr(44, 32'h60, "R8 mode off"); rd(24, "R8 flushed flags"); rd(0, "R8 flushed data");
    step(1, 1, 44, 32'h10, 1, 8'hAB, "R8 toggle with push"); rd(0, "R8 push after flush");

    // R9: identification window, unmapped and unaligned
    for (int i = 0; i < 8; i++) rd(12'hFE0 + i * 4, "R9 id");
    rd(8, "R9 unmapped"); rd(28, "R9 unmapped"); rd(49, "R9 unaligned");
    wr(50, 32'hFFFF, "R9 unaligned write"); rd(48, "R9 ctrl intact");
    idle("end"); idle("end");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule